// File: doc/BRIEF.md
# GPIO Port Controller

This block is a sixteen-pin general-purpose I/O port behind a 32-bit register interface. Software selects, for each pin, one of four modes (input, general output, alternate function, analog). It also sets the output stage (push-pull or open-drain), a two-bit slew/speed code, a pull selection and a four-bit alternate-function number. An output latch holds the general-output levels. The latch can be written as a whole, or changed atomically through a set/clear word in which the low half raises bits and the high half lowers them. Pin levels are brought into the clock domain by a synchronizer and can be read back separately from the latch.

Toward the pad ring the block presents an output enable, an output value, an open-drain flag, pull-up and pull-down enables, the speed code and the alternate-function number of every pin. In alternate mode the output value is taken from an external alternate-peripheral output vector, one bit per pin, instead of the latch. All pad controls are decoded combinationally from the registers, so they change in the cycle after the write that sets them.

The bus is a plain synchronous request port. The master holds `bus_sel` high for one cycle per access. `bus_ready` follows one cycle later, with read data valid in that same cycle. The port never stalls, so back-to-back accesses may be issued on consecutive cycles.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register reads zero. All pins are floating inputs with output enable, pulls, speed and alternate-function select all zero.
- R2: `bus_ready` is high exactly in the cycle after each cycle in which `bus_sel` is high. Read data is valid in that cycle, including for back-to-back reads.
- R3: The configuration words at byte offsets 0x00 (mode, 2 bits per pin at pin*2), 0x04 (output type, bit n), 0x08 (speed, 2 bits at pin*2), 0x0C (pull, 2 bits at pin*2), 0x20 (alternate number of pins 0-7, 4 bits at pin*4) and 0x24 (pins 8-15, 4 bits at (pin-8)*4) read back what was written. Bits 31:16 of the output-type word read zero.
- R4: A write to 0x18 raises latch bit n for each set bit n in 15:0 and lowers latch bit n for each set bit n+16. Latch bits with neither bit set keep their value.
- R5: When bit n and bit n+16 are both set in one write to 0x18, latch bit n ends high.
- R6: A write to 0x14 loads the latch with bits 15:0. A read of 0x14 returns the latch. No other access changes the latch.
- R7: Offset 0x10 returns pin levels through a two-flop synchronizer. A level applied before clock edge k is returned by a read whose data is captured at edge k+2. It is not returned by reads captured at edge k or k+1.
- R8: Reads of 0x18, of the lock word 0x1C, of unmapped words and of addresses with nonzero bits 1:0 return zero. Writes to those addresses change no register and no pad output.
- R9: A pin's output enable can be high only in mode 1 (output) or mode 2 (alternate). Modes 0 and 3 never drive.
- R10: In mode 1 the pad value is the latch bit. In mode 2 it is the pin's bit of the alternate-peripheral input, independent of the latch.
- R11: With output type 1 (open-drain) a pin in mode 1 or 2 is enabled only while its value is 0. With type 0 it is enabled for both values. The open-drain flag equals the output-type bit.
- R12: Pull code 1 enables the pull-up, code 2 enables the pull-down, and codes 0 and 3 enable neither. The speed output equals the speed word. The alternate-function select of pin n is its 4-bit number at bits 4n+3:4n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Access completion, one cycle after bus_sel |
| pad_in | input | 16 | Asynchronous pin levels |
| alt_do | input | 16 | Alternate-peripheral output level per pin |
| pad_oe | output | 16 | Pad output enable per pin |
| pad_out | output | 16 | Pad output value per pin |
| pad_od | output | 16 | Open-drain flag per pin |
| pad_pu | output | 16 | Pull-up enable per pin |
| pad_pd | output | 16 | Pull-down enable per pin |
| pad_speed | output | 32 | Speed code, 2 bits per pin |
| pad_af_sel | output | 64 | Alternate-function number, 4 bits per pin |

## Verification
The hardest behaviour to pin down from the ports is the synchronizer latency. A pin change is visible to software only through a registered read, so the bench changes the pins on a falling edge and issues three reads back to back, one per cycle. It expects the old value twice and then the new one. The set-wins case also needs care, because it is only visible when the affected latch bit starts low. The bench therefore first loads a known latch pattern through the direct data word, then writes set and clear together on a bit that is 0 and on a bit that is 1.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned BUS_DW = 32;

  typedef enum logic [1:0] {
    PM_INPUT  = 2'd0,
    PM_OUTPUT = 2'd1,
    PM_ALTFN  = 2'd2,
    PM_ANALOG = 2'd3
  } pin_mode_e;

  // Word index = byte address / 4; software depends on these values.
  localparam logic [3:0] WI_MODE   = 4'd0;
  localparam logic [3:0] WI_OTYPE  = 4'd1;
  localparam logic [3:0] WI_SPEED  = 4'd2;
  localparam logic [3:0] WI_PULL   = 4'd3;
  localparam logic [3:0] WI_IN     = 4'd4;
  localparam logic [3:0] WI_OUT    = 4'd5;
  localparam logic [3:0] WI_SETCLR = 4'd6;
  localparam logic [3:0] WI_LOCK   = 4'd7;
  localparam logic [3:0] WI_AFLO   = 4'd8;
  localparam logic [3:0] WI_AFHI   = 4'd9;

  localparam logic [1:0] PULL_UP_CODE   = 2'd1;
  localparam logic [1:0] PULL_DOWN_CODE = 2'd2;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] sync_out
);
  logic [NPINS-1:0] stage_q [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= pad_in;
      for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[SYNC_STAGES-1];

  // Cycles since reset, saturating, so the latency check never looks before reset.
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  generate
    if (SYNC_STAGES == 2) begin : g_lat_chk
      // R7: two-edge latency from pin to synchronized value
      a_r7_two_flop_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (sync_out == $past(pad_in, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned AW    = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [AW-1:0]        bus_addr,
  input  logic [BUS_DW-1:0]    bus_wdata,
  output logic [BUS_DW-1:0]    bus_rdata,
  output logic                 bus_ready,
  input  logic [NPINS-1:0]     in_sync,
  output logic [2*NPINS-1:0]   mode_q,
  output logic [NPINS-1:0]     otype_q,
  output logic [2*NPINS-1:0]   speed_q,
  output logic [2*NPINS-1:0]   pull_q,
  output logic [4*NPINS-1:0]   af_q,
  output logic [NPINS-1:0]     latch_q
);
  localparam int unsigned AFW     = BUS_DW / 4;   // alternate numbers per word
  localparam int unsigned CLR_LSB = BUS_DW / 2;   // first clear bit of set/clear word
  localparam int unsigned WIW     = AW - 2;

  logic [WIW-1:0] widx;
  logic           aligned;
  assign widx    = bus_addr[AW-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  function automatic logic word_is(input logic [WIW-1:0] w, input logic [3:0] code);
    return w == WIW'(code);
  endfunction

  logic wr, rd;
  assign wr = bus_sel && bus_we && aligned;
  assign rd = bus_sel && !bus_we;

  logic hit_setclr, hit_out;
  assign hit_setclr = wr && word_is(widx, WI_SETCLR);
  assign hit_out    = wr && word_is(widx, WI_OUT);

  logic [NPINS-1:0] set_bits, clr_bits;
  assign set_bits = bus_wdata[NPINS-1:0];
  assign clr_bits = bus_wdata[CLR_LSB +: NPINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      af_q    <= '0;
      latch_q <= '0;
    end else if (wr) begin
      if (word_is(widx, WI_MODE))  mode_q  <= bus_wdata[2*NPINS-1:0];
      if (word_is(widx, WI_OTYPE)) otype_q <= bus_wdata[NPINS-1:0];
      if (word_is(widx, WI_SPEED)) speed_q <= bus_wdata[2*NPINS-1:0];
      if (word_is(widx, WI_PULL))  pull_q  <= bus_wdata[2*NPINS-1:0];
      if (hit_out)                 latch_q <= set_bits;
      // Clear first, then set: a pin named in both halves ends high.
      if (hit_setclr)              latch_q <= (latch_q & ~clr_bits) | set_bits;
      for (int n = 0; n < NPINS; n++) begin
        if ((n < AFW) ? word_is(widx, WI_AFLO) : word_is(widx, WI_AFHI))
          af_q[4*n +: 4] <= bus_wdata[4*(n % AFW) +: 4];
      end
    end
  end

  logic [BUS_DW-1:0] af_lo_word, af_hi_word, rd_mux;

  always_comb begin
    af_lo_word = '0;
    af_hi_word = '0;
    for (int n = 0; n < NPINS; n++) begin
      if (n < AFW) af_lo_word[4*(n % AFW) +: 4] = af_q[4*n +: 4];
      else         af_hi_word[4*(n % AFW) +: 4] = af_q[4*n +: 4];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (word_is(widx, WI_MODE))  rd_mux = BUS_DW'(mode_q);
      if (word_is(widx, WI_OTYPE)) rd_mux = BUS_DW'(otype_q);
      if (word_is(widx, WI_SPEED)) rd_mux = BUS_DW'(speed_q);
      if (word_is(widx, WI_PULL))  rd_mux = BUS_DW'(pull_q);
      if (word_is(widx, WI_IN))    rd_mux = BUS_DW'(in_sync);
      if (word_is(widx, WI_OUT))   rd_mux = BUS_DW'(latch_q);
      if (word_is(widx, WI_AFLO))  rd_mux = af_lo_word;
      if (word_is(widx, WI_AFHI))  rd_mux = af_hi_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_sel;
      if (rd) bus_rdata <= rd_mux;
    end
  end

  // R2: completion exactly one cycle after each request
  a_r2_ready_after_sel: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> bus_ready);
  a_r2_no_spurious_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !bus_ready);

  // R4/R5: every requested set bit is high afterwards, even if also cleared
  a_r5_set_bits_high: assert property (@(posedge clk) disable iff (!rst_n)
    hit_setclr |=> ((latch_q & $past(set_bits)) == $past(set_bits)));
  // R4: clear-only bits are low afterwards
  a_r4_clear_bits_low: assert property (@(posedge clk) disable iff (!rst_n)
    hit_setclr |=> ((latch_q & $past(clr_bits & ~set_bits)) == '0));

  // R6: latch moves only on its two write words
  a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_out || hit_setclr) |=> $stable(latch_q));

  // R8: lock and set/clear words read zero
  a_r8_lock_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && aligned && word_is(widx, WI_LOCK)) |=> (bus_rdata == '0));
  a_r8_setclr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && aligned && word_is(widx, WI_SETCLR)) |=> (bus_rdata == '0));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*NPINS-1:0] mode_q,
  input  logic [NPINS-1:0]   otype_q,
  input  logic [2*NPINS-1:0] speed_q,
  input  logic [2*NPINS-1:0] pull_q,
  input  logic [4*NPINS-1:0] af_q,
  input  logic [NPINS-1:0]   latch_q,
  input  logic [NPINS-1:0]   alt_do,
  output logic [NPINS-1:0]   pad_oe,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_od,
  output logic [NPINS-1:0]   pad_pu,
  output logic [NPINS-1:0]   pad_pd,
  output logic [2*NPINS-1:0] pad_speed,
  output logic [4*NPINS-1:0] pad_af_sel
);
  assign pad_speed  = speed_q;
  assign pad_af_sel = af_q;
  assign pad_od     = otype_q;

  generate
    for (genvar n = 0; n < NPINS; n++) begin : g_pin
      pin_mode_e  m;
      logic [1:0] pl;
      logic       drv, active;

      assign m      = pin_mode_e'(mode_q[2*n +: 2]);
      assign pl     = pull_q[2*n +: 2];
      assign drv    = (m == PM_ALTFN) ? alt_do[n] : latch_q[n];
      assign active = (m == PM_OUTPUT) || (m == PM_ALTFN);

      assign pad_out[n] = drv;
      assign pad_oe[n]  = active && (!otype_q[n] || !drv);
      assign pad_pu[n]  = (pl == PULL_UP_CODE);
      assign pad_pd[n]  = (pl == PULL_DOWN_CODE);

      // R9: only output and alternate modes drive
      a_r9_oe_needs_drive_mode: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[n] |-> (mode_q[2*n +: 2] == 2'd1 || mode_q[2*n +: 2] == 2'd2));
      // R11: an open-drain pin never drives a high level
      a_r11_od_drives_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[n] && pad_od[n]) |-> !pad_out[n]);
      // R12: the two pulls are never on together
      a_r12_pulls_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pad_pu[n] && pad_pd[n]));
    end
  endgenerate
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS       = 16,
  parameter int unsigned AW          = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_ready,
  input  logic [NPINS-1:0]   pad_in,
  input  logic [NPINS-1:0]   alt_do,
  output logic [NPINS-1:0]   pad_oe,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_od,
  output logic [NPINS-1:0]   pad_pu,
  output logic [NPINS-1:0]   pad_pd,
  output logic [2*NPINS-1:0] pad_speed,
  output logic [4*NPINS-1:0] pad_af_sel
);
  logic [NPINS-1:0]   in_sync;
  logic [2*NPINS-1:0] mode_q, speed_q, pull_q;
  logic [NPINS-1:0]   otype_q, latch_q;
  logic [4*NPINS-1:0] af_q;

  initial begin
    if (NPINS > BUS_DW / 2 || AW < 6 || SYNC_STAGES < 2)
      $error("gpio_port_ctrl: unsupported parameter set");
  end

  gpio_in_sync #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_in   (pad_in),
    .sync_out (in_sync)
  );

  gpio_cfg_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .in_sync   (in_sync),
    .mode_q    (mode_q),
    .otype_q   (otype_q),
    .speed_q   (speed_q),
    .pull_q    (pull_q),
    .af_q      (af_q),
    .latch_q   (latch_q)
  );

  gpio_pad_drive #(.NPINS(NPINS)) u_pads (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_q     (mode_q),
    .otype_q    (otype_q),
    .speed_q    (speed_q),
    .pull_q     (pull_q),
    .af_q       (af_q),
    .latch_q    (latch_q),
    .alt_do     (alt_do),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .pad_od     (pad_od),
    .pad_pu     (pad_pu),
    .pad_pd     (pad_pd),
    .pad_speed  (pad_speed),
    .pad_af_sel (pad_af_sel)
  );
endmodule

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;

  localparam logic [5:0] A_MODE = 6'h00, A_OTYPE = 6'h04, A_SPEED = 6'h08,
                         A_PULL = 6'h0C, A_IN = 6'h10, A_OUT = 6'h14,
                         A_SETCLR = 6'h18, A_LOCK = 6'h1C, A_AFLO = 6'h20,
                         A_AFHI = 6'h24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ready;
  logic [15:0] pad_in, alt_do;
  logic [15:0] pad_oe, pad_out, pad_od, pad_pu, pad_pd;
  logic [31:0] pad_speed;
  logic [63:0] pad_af_sel;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .pad_in(pad_in), .alt_do(alt_do),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_od(pad_od), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .pad_speed(pad_speed), .pad_af_sel(pad_af_sel)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All bus tasks start and end on a falling edge.
  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    chk("R2 ready with read data", 64'(bus_ready), 64'd1);
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    logic [5:0] addrs [10] = '{A_MODE, A_OTYPE, A_SPEED, A_PULL, A_IN,
                               A_OUT, A_SETCLR, A_LOCK, A_AFLO, A_AFHI};
    chk("R1 oe after reset", 64'(pad_oe), 64'd0);
    chk("R1 pulls after reset", {pad_pu, pad_pd}, 64'd0);
    chk("R1 speed after reset", 64'(pad_speed), 64'd0);
    chk("R1 af select after reset", pad_af_sel, 64'd0);
    for (int i = 0; i < 10; i++) begin
      bus_read(addrs[i], d);
      chk("R1 register zero after reset", 64'(d), 64'd0);
    end
  endtask

  task automatic t_bus_timing();
    @(negedge clk);
    chk("R2 idle ready low", 64'(bus_ready), 64'd0);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_OUT; bus_wdata = 32'h0000_1234;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = A_OUT;
    @(negedge clk);
    chk("R2 back-to-back ready", 64'(bus_ready), 64'd1);
    chk("R2 back-to-back read data", 64'(bus_rdata), 64'h1234);
    bus_sel = 1'b0;
    @(negedge clk);
    chk("R2 ready drops after last access", 64'(bus_ready), 64'd0);
  endtask

  task automatic t_config();
    logic [31:0] d;
    bus_write(A_MODE, 32'h9C6E_1B24);
    bus_write(A_OTYPE, 32'hFFFF_A5C3);
    bus_write(A_SPEED, 32'h1B1B_1B1B);
    bus_write(A_PULL, 32'hE4E4_E4E4);
    bus_write(A_AFLO, 32'h7654_3210);
    bus_write(A_AFHI, 32'hFEDC_BA98);
    bus_read(A_MODE, d);  chk("R3 mode readback", 64'(d), 64'h9C6E_1B24);
    bus_read(A_OTYPE, d); chk("R3 otype readback upper zero", 64'(d), 64'h0000_A5C3);
    bus_read(A_SPEED, d); chk("R3 speed readback", 64'(d), 64'h1B1B_1B1B);
    bus_read(A_PULL, d);  chk("R3 pull readback", 64'(d), 64'hE4E4_E4E4);
    bus_read(A_AFLO, d);  chk("R3 af low readback", 64'(d), 64'h7654_3210);
    bus_read(A_AFHI, d);  chk("R3 af high readback", 64'(d), 64'hFEDC_BA98);
    // R12: pull code per pin is pin%4 -> up on 1,5,9,13; down on 2,6,10,14
    chk("R12 pull-up pins", 64'(pad_pu), 64'h2222);
    chk("R12 pull-down pins", 64'(pad_pd), 64'h4444);
    chk("R12 speed outputs", 64'(pad_speed), 64'h1B1B_1B1B);
    chk("R12 af select per pin", pad_af_sel, 64'hFEDC_BA98_7654_3210);
    chk("R11 od flag equals otype", 64'(pad_od), 64'hA5C3);
  endtask

  task automatic t_setclr();
    logic [31:0] d;
    bus_write(A_OUT, 32'hFFFF_00F0);
    bus_read(A_OUT, d); chk("R6 direct latch load", 64'(d), 64'h00F0);
    bus_write(A_SETCLR, 32'h0030_0101);
    bus_read(A_OUT, d); chk("R4 set 0,8 clear 4,5", 64'(d), 64'h01C1);
    bus_write(A_SETCLR, 32'h0042_0042);
    bus_read(A_OUT, d); chk("R5 set wins over clear", 64'(d), 64'h01C3);
    bus_read(A_SETCLR, d); chk("R8 set/clear reads zero", 64'(d), 64'd0);
    bus_write(A_SETCLR, 32'h0000_0000);
    bus_read(A_OUT, d); chk("R4 zero write keeps latch", 64'(d), 64'h01C3);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    logic [15:0] oe_before;
    oe_before = pad_oe;
    bus_write(A_LOCK, 32'hFFFF_FFFF);
    bus_write(6'h01, 32'hFFFF_FFFF);  // misaligned: aimed at mode word
    bus_write(6'h3C, 32'hFFFF_FFFF);  // unmapped
    bus_read(A_LOCK, d); chk("R8 lock reads zero", 64'(d), 64'd0);
    bus_read(6'h3C, d);  chk("R8 unmapped reads zero", 64'(d), 64'd0);
    bus_read(6'h15, d);  chk("R8 misaligned read zero", 64'(d), 64'd0);
    bus_read(A_MODE, d); chk("R8 ignored writes keep mode", 64'(d), 64'h9C6E_1B24);
    bus_read(A_OUT, d);  chk("R8 ignored writes keep latch", 64'(d), 64'h01C3);
    chk("R8 ignored writes keep pads", 64'(pad_oe), 64'(oe_before));
  endtask

  task automatic t_input_sync();
    logic [31:0] d;
    pad_in = 16'h0000;
    repeat (3) @(negedge clk);
    pad_in = 16'hA55A;
    bus_read(A_IN, d); chk("R7 first edge still old", 64'(d), 64'h0000);
    bus_read(A_IN, d); chk("R7 second edge still old", 64'(d), 64'h0000);
    bus_read(A_IN, d); chk("R7 third edge new value", 64'(d), 64'hA55A);
    pad_in = 16'h0F0F;
    repeat (3) @(negedge clk);
    bus_read(A_IN, d); chk("R7 settled pattern", 64'(d), 64'h0F0F);
  endtask

  task automatic t_pad_modes();
    // pin0 input, pin1 output, pin2 alternate, pin3 analog,
    // pin4 output open-drain, pin5 alternate open-drain
    bus_write(A_MODE, 32'h0000_09E4);
    bus_write(A_OTYPE, 32'h0000_0030);
    bus_write(A_OUT, 32'h0000_0013);   // latch pins 0,1,4 high
    alt_do = 16'h0004;                 // alt pin2 high, pin5 low
    @(negedge clk);
    chk("R9 R11 oe for mixed modes", 64'(pad_oe), 64'h0026);
    chk("R10 driven values", 64'(pad_out & pad_oe), 64'h0006);
    bus_write(A_SETCLR, 32'h0010_0000); // pin4 latch low
    chk("R11 od output low enabled", 64'(pad_oe), 64'h0036);
    chk("R11 od output value low", 64'(pad_out[4]), 64'd0);
    bus_write(A_SETCLR, 32'h0000_0004); // latch pin2 high, alt pin2 low
    alt_do = 16'h0020;                  // pin5 alt high -> od released
    @(negedge clk);
    chk("R10 alt ignores latch", 64'(pad_out[2]), 64'd0);
    chk("R11 od high releases pad", 64'(pad_oe), 64'h0016);
    bus_write(A_OTYPE, 32'h0000_0000);
    chk("R11 push-pull drives high", 64'(pad_oe), 64'h0036);
    chk("R10 output pin follows latch", 64'(pad_out[1]), 64'd1);
    bus_write(A_MODE, 32'h0000_0000);
    chk("R9 input mode never drives", 64'(pad_oe), 64'd0);
    bus_write(A_MODE, 32'hFFFF_FFFF);
    chk("R9 analog mode never drives", 64'(pad_oe), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0; alt_do = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bus_timing();
    t_config();
    t_setclr();
    t_lock();
    t_input_sync();
    t_pad_modes();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule